// File: doc/BRIEF.md
# Serial Controller FIFO Status and Interrupt Unit

This block sits between a register port and the shift engine of a serial controller. It holds one word queue for outgoing data and one for incoming data, reports how full each queue is, and turns those fill levels and the misuse of either queue into interrupt and DMA request outputs. Software writes outgoing words and reads incoming words through the register port. The shift engine takes words from the outgoing queue and delivers words into the incoming queue.

Each queue has a programmable threshold that drives a level interrupt and a programmable watermark that drives a DMA request. Three error conditions are latched until software clears them: a write into a full outgoing queue, a read from an empty incoming queue, and a delivery into a full incoming queue. A mask selects which interrupt sources reach the single interrupt output.

Top module: `sfs_unit`

## Requirements
- R1: After reset both queues are empty, thresholds, watermarks, mask and DMA enables are zero, the status word reads 0x000C, and `irq`, `dma_tx_req`, `dma_rx_req` and `eng_tx_avail` are low. Register indices on `reg_addr`: 0 outgoing data (write pushes), 1 incoming data (read pops), 2 outgoing level, 3 incoming level, 4 outgoing threshold, 5 incoming threshold, 6 status, 7 mask, 8 masked interrupts, 9 raw interrupts, 10 clear (write only), 11 DMA enables, 12 outgoing watermark, 13 incoming watermark.
- R2: A write to index 0 appends a word to the outgoing queue; the engine sees the oldest word on `eng_tx_data`, `eng_tx_avail` is high while the queue holds a word, and `eng_tx_pop` removes it; index 2 reads the entry count.
- R3: `eng_rx_push` appends `eng_rx_data` to the incoming queue; a read of index 1 returns the oldest word and removes it when the count is above zero; index 3 reads the entry count.
- R4: The status word has bit0 busy (`eng_busy` high or outgoing queue not empty), bit1 outgoing full, bit2 outgoing empty, bit3 incoming empty, bit4 incoming full.
- R5: A threshold write is stored only when the value is below the queue depth; a larger value leaves the previous threshold in place.
- R6: Raw interrupt bit0 is high while the outgoing count is at or below its threshold and bit4 is high while the incoming count is above its threshold; both follow the live counts.
- R7: Raw bit1 latches on a write to a full outgoing queue, bit2 on a read of an empty incoming queue, bit3 on an engine delivery into a full incoming queue; the offending word is dropped and the count is unchanged.
- R8: Writing the clear register with bit0 clears all three error bits, bit1 clears bit2 (incoming underflow), bit2 clears bit3 (incoming overflow), bit3 clears bit1 (outgoing overflow); an error arriving in the same cycle as its clear stays set.
- R9: The masked interrupt register reads the raw bits ANDed with the 5-bit mask, and `irq` is high when any masked bit is high.
- R10: DMA enable bit1 gates `dma_tx_req`, high while the outgoing count is at or below its watermark; bit0 gates `dma_rx_req`, high while the incoming count is above its watermark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on incoming data index) |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational |
| eng_busy | input | 1 | Shift engine is mid-word |
| eng_tx_pop | input | 1 | Engine takes the oldest outgoing word |
| eng_tx_data | output | 16 | Oldest outgoing word |
| eng_tx_avail | output | 1 | Outgoing queue holds at least one word |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | 16 | Received word |
| irq | output | 1 | OR of the masked interrupt bits |
| dma_tx_req | output | 1 | Request to refill the outgoing queue |
| dma_rx_req | output | 1 | Request to drain the incoming queue |

## Verification
The two functions that can collide in one cycle are the latching of an error and its clear by software: the engine delivers a word into a full incoming queue on the very clock edge at which the clear register is written with the incoming-overflow clear bit. The bench drives both strobes from the same falling edge, then reads the raw interrupt register and expects the overflow bit still set; a following clear on its own must remove it, and a clear of a different bit in between must leave it alone.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
    // register indices
    localparam logic [3:0] A_TXD    = 4'd0;
    localparam logic [3:0] A_RXD    = 4'd1;
    localparam logic [3:0] A_TXLVL  = 4'd2;
    localparam logic [3:0] A_RXLVL  = 4'd3;
    localparam logic [3:0] A_TXTHR  = 4'd4;
    localparam logic [3:0] A_RXTHR  = 4'd5;
    localparam logic [3:0] A_STAT   = 4'd6;
    localparam logic [3:0] A_IMASK  = 4'd7;
    localparam logic [3:0] A_ISTAT  = 4'd8;
    localparam logic [3:0] A_IRAW   = 4'd9;
    localparam logic [3:0] A_ICLR   = 4'd10;
    localparam logic [3:0] A_DMACTL = 4'd11;
    localparam logic [3:0] A_TXWM   = 4'd12;
    localparam logic [3:0] A_RXWM   = 4'd13;

    // interrupt bit positions
    localparam int IB_TXLOW  = 0;
    localparam int IB_TXOVF  = 1;
    localparam int IB_RXUDF  = 2;
    localparam int IB_RXOVF  = 3;
    localparam int IB_RXHIGH = 4;
    localparam int NIRQ      = 5;
endpackage

// File: rtl/sfs_fifo.sv
module sfs_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [DW-1:0]              push_data,
    input  logic                       pop,
    output logic [DW-1:0]              head,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       full,
    output logic                       empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [LW-1:0] lvl;
    } fst_t;

    fst_t          s_q, s_d;
    logic [DW-1:0] mem_q [DEPTH];
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (s_q.lvl == LW'(DEPTH));
    assign empty   = (s_q.lvl == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_comb begin
        s_d = s_q;
        if (do_push) s_d.wp = bump(s_q.wp);
        if (do_pop)  s_d.rp = bump(s_q.rp);
        case ({do_push, do_pop})
            2'b10:   s_d.lvl = s_q.lvl + 1'b1;
            2'b01:   s_d.lvl = s_q.lvl - 1'b1;
            default: s_d.lvl = s_q.lvl;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[s_q.wp] <= push_data;
    end

    assign head  = mem_q[s_q.rp];
    assign level = s_q.lvl;

    // R2: the count never exceeds the depth
    a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(s_q.lvl) <= DEPTH);

    // R7: a push into a full queue without a pop leaves the count alone
    a_r7_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> $stable(level));
endmodule

// File: rtl/sfs_ctrl.sv
module sfs_ctrl
    import sfs_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_wr,
    input  logic                       reg_rd,
    input  logic [3:0]                 reg_addr,
    input  logic [DW-1:0]              reg_wdata,
    output logic [DW-1:0]              reg_rdata,
    input  logic                       eng_busy,
    input  logic                       eng_rx_push,
    input  logic [$clog2(DEPTH+1)-1:0] tx_lvl,
    input  logic [$clog2(DEPTH+1)-1:0] rx_lvl,
    input  logic [DW-1:0]              rx_head,
    output logic                       tx_push,
    output logic                       rx_pop,
    output logic                       irq,
    output logic                       dma_tx_req,
    output logic                       dma_rx_req
);
    localparam int LW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [LW-1:0]   tx_thr;
        logic [LW-1:0]   rx_thr;
        logic [LW-1:0]   tx_wm;
        logic [LW-1:0]   rx_wm;
        logic [NIRQ-1:0] mask;
        logic [1:0]      dma_en;
        logic            err_txovf;
        logic            err_rxudf;
        logic            err_rxovf;
    } cst_t;

    cst_t            c_q, c_d;
    logic            tx_full, tx_empty, rx_full, rx_empty;
    logic            ev_txovf, ev_rxudf, ev_rxovf;
    logic            clr_hit, clr_all, clr_udf, clr_rovf, clr_tovf;
    logic            thr_ok;
    logic [NIRQ-1:0] raw, masked, stat;

    assign tx_full  = (tx_lvl == LW'(DEPTH));
    assign tx_empty = (tx_lvl == '0);
    assign rx_full  = (rx_lvl == LW'(DEPTH));
    assign rx_empty = (rx_lvl == '0);

    assign tx_push  = reg_wr && (reg_addr == A_TXD);
    assign rx_pop   = reg_rd && (reg_addr == A_RXD);
    assign ev_txovf = tx_push && tx_full;
    assign ev_rxudf = rx_pop && rx_empty;
    assign ev_rxovf = eng_rx_push && rx_full;

    assign clr_hit  = reg_wr && (reg_addr == A_ICLR);
    assign clr_all  = clr_hit && reg_wdata[0];
    assign clr_udf  = clr_hit && reg_wdata[1];
    assign clr_rovf = clr_hit && reg_wdata[2];
    assign clr_tovf = clr_hit && reg_wdata[3];

    assign thr_ok = (reg_wdata < DW'(DEPTH));

    always_comb begin
        c_d = c_q;
        if (reg_wr) begin
            case (reg_addr)
                A_TXTHR:  if (thr_ok) c_d.tx_thr = reg_wdata[LW-1:0];
                A_RXTHR:  if (thr_ok) c_d.rx_thr = reg_wdata[LW-1:0];
                A_TXWM:   c_d.tx_wm  = reg_wdata[LW-1:0];
                A_RXWM:   c_d.rx_wm  = reg_wdata[LW-1:0];
                A_IMASK:  c_d.mask   = reg_wdata[NIRQ-1:0];
                A_DMACTL: c_d.dma_en = reg_wdata[1:0];
                default:  ;
            endcase
        end
        // clear first, then a new event wins
        c_d.err_txovf = (c_q.err_txovf && !(clr_all || clr_tovf)) || ev_txovf;
        c_d.err_rxudf = (c_q.err_rxudf && !(clr_all || clr_udf))  || ev_rxudf;
        c_d.err_rxovf = (c_q.err_rxovf && !(clr_all || clr_rovf)) || ev_rxovf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    always_comb begin
        raw            = '0;
        raw[IB_TXLOW]  = (tx_lvl <= c_q.tx_thr);
        raw[IB_TXOVF]  = c_q.err_txovf;
        raw[IB_RXUDF]  = c_q.err_rxudf;
        raw[IB_RXOVF]  = c_q.err_rxovf;
        raw[IB_RXHIGH] = (rx_lvl > c_q.rx_thr);
    end

    assign masked     = raw & c_q.mask;
    assign irq        = |masked;
    assign stat       = {rx_full, rx_empty, tx_empty, tx_full, eng_busy || !tx_empty};
    assign dma_tx_req = c_q.dma_en[1] && (tx_lvl <= c_q.tx_wm);
    assign dma_rx_req = c_q.dma_en[0] && (rx_lvl > c_q.rx_wm);

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_RXD:    reg_rdata = rx_head;
            A_TXLVL:  reg_rdata = DW'(tx_lvl);
            A_RXLVL:  reg_rdata = DW'(rx_lvl);
            A_TXTHR:  reg_rdata = DW'(c_q.tx_thr);
            A_RXTHR:  reg_rdata = DW'(c_q.rx_thr);
            A_STAT:   reg_rdata = DW'(stat);
            A_IMASK:  reg_rdata = DW'(c_q.mask);
            A_ISTAT:  reg_rdata = DW'(masked);
            A_IRAW:   reg_rdata = DW'(raw);
            A_DMACTL: reg_rdata = DW'(c_q.dma_en);
            A_TXWM:   reg_rdata = DW'(c_q.tx_wm);
            A_RXWM:   reg_rdata = DW'(c_q.rx_wm);
            default:  reg_rdata = '0;
        endcase
    end

    // R5: stored thresholds stay below the depth
    a_r5_thr_below_depth: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(c_q.tx_thr) < DEPTH) && (int'(c_q.rx_thr) < DEPTH));

    // R7: a write into a full outgoing queue raises the overflow bit
    a_r7_txovf_latches: assert property (@(posedge clk) disable iff (!rst_n)
        ev_txovf |=> raw[IB_TXOVF]);

    // R8: incoming overflow holds until a matching clear
    a_r8_rxovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (raw[IB_RXOVF] && !(clr_all || clr_rovf)) |=> raw[IB_RXOVF]);

    // R9: nothing reaches the output with an all-zero mask
    a_r9_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.mask == '0) |-> !irq);

    // R10: requests stay low while their enables are off
    a_r10_dma_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_q.dma_en[1] |-> !dma_tx_req) and (!c_q.dma_en[0] |-> !dma_rx_req));
endmodule

// File: rtl/sfs_unit.sv
module sfs_unit #(
    parameter int DW    = 16,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [3:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          eng_busy,
    input  logic          eng_tx_pop,
    output logic [DW-1:0] eng_tx_data,
    output logic          eng_tx_avail,
    input  logic          eng_rx_push,
    input  logic [DW-1:0] eng_rx_data,
    output logic          irq,
    output logic          dma_tx_req,
    output logic          dma_rx_req
);
    localparam int LW = $clog2(DEPTH + 1);

    logic [LW-1:0] tx_lvl, rx_lvl;
    logic [DW-1:0] rx_head;
    logic          tx_push, rx_pop;
    logic          tx_full, tx_empty, rx_full, rx_empty;

    sfs_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .push_data(reg_wdata), .pop(eng_tx_pop),
        .head(eng_tx_data), .level(tx_lvl), .full(tx_full), .empty(tx_empty)
    );

    sfs_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(eng_rx_push), .push_data(eng_rx_data), .pop(rx_pop),
        .head(rx_head), .level(rx_lvl), .full(rx_full), .empty(rx_empty)
    );

    sfs_ctrl #(.DW(DW), .DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_busy(eng_busy), .eng_rx_push(eng_rx_push),
        .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .rx_head(rx_head),
        .tx_push(tx_push), .rx_pop(rx_pop),
        .irq(irq), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
    );

    assign eng_tx_avail = !tx_empty;

    // R3: the incoming queue flags never claim full and empty together
    a_r3_rx_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_full && rx_empty));

    // R2: an engine take from a non-empty queue lowers the count
    a_r2_take_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_tx_pop && !tx_empty && !tx_push) |=> (tx_lvl == $past(tx_lvl) - 1'b1));
endmodule

// File: tb/sfs_unit_tb_top.sv
module sfs_unit_tb_top;
    import sfs_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        eng_busy = 1'b0, eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
    logic [15:0] eng_tx_data, eng_rx_data = '0;
    logic        eng_tx_avail, irq, dma_tx_req, dma_rx_req;

    int nchk = 0;
    int nbad = 0;

    always #10 clk = ~clk;

    sfs_unit dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_busy(eng_busy), .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
        .eng_tx_avail(eng_tx_avail), .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
        .irq(irq), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
    );

    typedef struct packed {
        logic [1:0]  op;   // 0 write, 1 read and compare
        logic [3:0]  adr;
        logic [15:0] dat;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t TBL [NV] = '{
        '{2'd1, 4'd6,  16'h000C, 4'd1},  // R1 status after reset
        '{2'd1, 4'd4,  16'h0000, 4'd1},  // R1 threshold after reset
        '{2'd0, 4'd4,  16'h0007, 4'd5},
        '{2'd1, 4'd4,  16'h0007, 4'd5},  // R5 largest legal value
        '{2'd0, 4'd4,  16'h0008, 4'd5},
        '{2'd1, 4'd4,  16'h0007, 4'd5},  // R5 depth value ignored
        '{2'd0, 4'd4,  16'h0002, 4'd5},
        '{2'd1, 4'd4,  16'h0002, 4'd5},
        '{2'd0, 4'd7,  16'h001F, 4'd9},
        '{2'd1, 4'd9,  16'h0001, 4'd6},  // R6 outgoing low
        '{2'd0, 4'd0,  16'h1111, 4'd2},
        '{2'd0, 4'd0,  16'h2222, 4'd2},
        '{2'd0, 4'd0,  16'h3333, 4'd2},
        '{2'd1, 4'd2,  16'h0003, 4'd2},  // R2 count
        '{2'd1, 4'd9,  16'h0000, 4'd6},  // R6 above threshold
        '{2'd1, 4'd6,  16'h0009, 4'd4},  // R4 busy, not empty
        '{2'd0, 4'd0,  16'h4444, 4'd2},
        '{2'd0, 4'd0,  16'h5555, 4'd2},
        '{2'd0, 4'd0,  16'h6666, 4'd2},
        '{2'd0, 4'd0,  16'h7777, 4'd2},
        '{2'd0, 4'd0,  16'h8888, 4'd2},
        '{2'd1, 4'd6,  16'h000B, 4'd4},  // R4 full
        '{2'd0, 4'd0,  16'h9999, 4'd7},
        '{2'd1, 4'd2,  16'h0008, 4'd7},  // R7 word dropped
        '{2'd1, 4'd9,  16'h0002, 4'd7},  // R7 overflow latched
        '{2'd1, 4'd8,  16'h0002, 4'd9},  // R9 masked view
        '{2'd0, 4'd7,  16'h001D, 4'd9},
        '{2'd1, 4'd8,  16'h0000, 4'd9},  // R9 masked off
        '{2'd0, 4'd10, 16'h0008, 4'd8},
        '{2'd1, 4'd9,  16'h0000, 4'd8}   // R8 selective clear
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string tag);
        reg_rd = 1'b1; reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rd_only(input logic [3:0] a);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rx_in(input logic [15:0] d);
        eng_rx_push = 1'b1; eng_rx_data = d;
        @(negedge clk);
        eng_rx_push = 1'b0;
    endtask

    task automatic finish_run;
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 irq", 16'(irq), 16'h0);
        chk("R1 dma", {14'h0, dma_tx_req, dma_rx_req}, 16'h0);
        chk("R1 avail", 16'(eng_tx_avail), 16'h0);

        for (int i = 0; i < NV; i++) begin
            if (TBL[i].op == 2'd1)
                rd(TBL[i].adr, TBL[i].dat, $sformatf("R%0d vector %0d", TBL[i].req, i));
            else
                wr(TBL[i].adr, TBL[i].dat);
        end

        // R2: engine drains in order, the dropped word never appears
        for (int i = 0; i < 8; i++) begin
            #1;
            chk("R2 avail", 16'(eng_tx_avail), 16'h1);
            chk("R2 order", eng_tx_data, 16'h1111 * 16'(i + 1));
            eng_tx_pop = 1'b1;
            @(negedge clk);
            eng_tx_pop = 1'b0;
        end
        #1;
        chk("R2 drained", 16'(eng_tx_avail), 16'h0);
        chk("R9 irq on", 16'(irq), 16'h1);
        rd(A_TXLVL, 16'h0, "R7 nothing left after drop");

        // R4: engine busy alone
        eng_busy = 1'b1;
        rd(A_STAT, 16'h000D, "R4 busy input");
        eng_busy = 1'b0;

        // R3 / R6: incoming path
        wr(A_RXTHR, 16'h0001);
        rx_in(16'hA001);
        rx_in(16'hA002);
        rd(A_RXLVL, 16'h0002, "R3 count");
        rd(A_IRAW, 16'h0011, "R6 incoming high");
        rd(A_RXD, 16'hA001, "R3 oldest first");
        rd(A_RXLVL, 16'h0001, "R3 pop");
        rd(A_IRAW, 16'h0001, "R6 follows level");

        // R7: incoming overflow
        for (int i = 3; i <= 9; i++) rx_in(16'hA000 + 16'(i));
        rx_in(16'hA00A);
        rd(A_RXLVL, 16'h0008, "R7 rx count held");
        rd(A_STAT, 16'h0014, "R4 incoming full");
        rd(A_IRAW, 16'h0019, "R7 rx overflow");
        for (int i = 2; i <= 9; i++) rd(A_RXD, 16'hA000 + 16'(i), "R3 data after overflow");

        // R7: underflow
        rd_only(A_RXD);
        rd(A_RXLVL, 16'h0000, "R7 underflow no change");
        rd(A_IRAW, 16'h000D, "R7 underflow latched");

        // R8: clear all
        wr(A_ICLR, 16'h0001);
        rd(A_IRAW, 16'h0001, "R8 clear all");

        // R8: error and clear in the same cycle
        for (int i = 1; i <= 8; i++) rx_in(16'hB000 + 16'(i));
        rd(A_IRAW, 16'h0011, "R8 before collision");
        eng_rx_push = 1'b1; eng_rx_data = 16'hB009;
        reg_wr = 1'b1; reg_addr = A_ICLR; reg_wdata = 16'h0004;
        @(negedge clk);
        eng_rx_push = 1'b0; reg_wr = 1'b0;
        rd(A_IRAW, 16'h0019, "R8 new error wins over clear");
        wr(A_ICLR, 16'h0002);
        rd(A_IRAW, 16'h0019, "R8 other bit leaves overflow");
        wr(A_ICLR, 16'h0004);
        rd(A_IRAW, 16'h0011, "R8 overflow cleared");
        for (int i = 1; i <= 8; i++) rd(A_RXD, 16'hB000 + 16'(i), "R3 drain");

        // R10: DMA requests
        #1;
        chk("R10 off", {14'h0, dma_tx_req, dma_rx_req}, 16'h0);
        wr(A_DMACTL, 16'h0003);
        wr(A_TXWM, 16'h0001);
        wr(A_RXWM, 16'h0000);
        #1;
        chk("R10 tx low, rx empty", {14'h0, dma_tx_req, dma_rx_req}, 16'h2);
        wr(A_TXD, 16'hC001);
        wr(A_TXD, 16'hC002);
        rx_in(16'hD001);
        #1;
        chk("R10 tx above, rx above", {14'h0, dma_tx_req, dma_rx_req}, 16'h1);
        wr(A_DMACTL, 16'h0001);
        eng_tx_pop = 1'b1;
        @(negedge clk);
        eng_tx_pop = 1'b0;
        #1;
        chk("R10 tx disabled", {14'h0, dma_tx_req, dma_rx_req}, 16'h1);
        wr(A_DMACTL, 16'h0003);
        #1;
        chk("R10 tx re-enabled", {14'h0, dma_tx_req, dma_rx_req}, 16'h3);

        // R9: mask drives the output
        chk("R9 irq masked in", 16'(irq), 16'h1);
        wr(A_IMASK, 16'h0000);
        #1;
        chk("R9 irq masked out", 16'(irq), 16'h0);
        rd(A_ISTAT, 16'h0000, "R9 masked register zero");

        finish_run();
    end
endmodule